// File: doc/BRIEF.md
# Gated Multi-Channel Clock Rate Meter

This block measures the rate of several independent input clocks. Each input clock drives a free-running edge counter in its own domain. The counter is kept in Gray code, so only one bit changes per edge. A two-flop synchronizer brings each Gray value into a common counting clock, where it is converted back to binary. A gate timer in the counting clock marks a boundary every programmable number of cycles. At each boundary the block stores, for every channel, the number of edges seen since the previous boundary, and it flips an update toggle.

A third clock, the bus clock, synchronizes that toggle. When the synchronized toggle changes, the bus side takes a snapshot of all results and raises a sticky new-data flag. Software reads the results and the flag through a simple registered read port. A gate length of zero stops all measurement.

Top module: `clkrate_meter`

## Requirements
- R1: After reset, every channel result address and the status address read as zero.
- R2: Each channel counts the rising edges of its own input clock. For a gate of G counting-clock cycles, the result equals the number of input edges in that span, within one count.
- R3: The synchronized Gray code of each channel changes in at most one bit per counting-clock cycle.
- R4: While the gate length is zero, no boundary occurs. The update toggle holds, and the new-data flag stays clear.
- R5: A result is the current synchronized count minus the count taken at the previous boundary, modulo 2^32. A channel whose clock has stopped for a whole interval reports exactly zero.
- R6: While the gate length is zero, the previous-boundary sample follows the live count. The first result after measurement is enabled therefore covers only the first new interval.
- R7: The results in the counting domain change only at a boundary, when the update toggle also flips. The new-data flag is set only when the bus side captures after a toggle change.
- R8: Reading address NUM_CH (the status word) returns the new-data flag in bit 0 and clears the flag. If a capture happens in the same cycle as the read, the flag stays set.
- R9: Read data appears on the bus clock edge after rd_en is sampled. Addresses 0 to NUM_CH-1 return the channel results. Addresses above NUM_CH return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | NUM_CH | One measured clock per channel |
| cnt_clk | input | 1 | Counting clock; runs the gate timer |
| bus_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| gate_len | input | 32 | Gate interval in counting-clock cycles; zero disables |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address: channels, then status |
| rd_data | output | 32 | Registered read data |

## Verification
A read returns data on the bus edge after the strobe, so the bench samples rd_data at the following falling edge. A new result reaches the bus side a few cycles after a boundary: the counter takes about two to three counting cycles to synchronize, and the toggle takes two to three bus cycles. The bench does not predict that variable delay. It polls the status word until the flag is set, and only then reads the channels. After any change to the gate length, the bench discards the first published result and checks the second, so every checked value covers a full interval of G counting cycles. Synchronizer phase can shift a count by one edge. The bench therefore compares count times period against G times the counting period, with a tolerance of one input period.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;
    localparam int CNT_W  = 32;
    localparam int NUM_CH = 3;
endpackage

// File: rtl/fm_edge_counter.sv
module fm_edge_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] gray_o
);
    typedef struct packed {
        logic [W-1:0] bin;
        logic [W-1:0] gray;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bin  = st_q.bin + 1'b1;
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_o = st_q.gray;
endmodule

// File: rtl/fm_gray_sync.sv
module fm_gray_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] gray_o,
    output logic [W-1:0] bin_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = gray_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bin_o[W-1] = st_q.s2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ st_q.s2[i];
        end
    end

    assign gray_o = st_q.s2;
endmodule

// File: rtl/fm_gate_core.sv
module fm_gate_core #(
    parameter int NCH = 3,
    parameter int W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [W-1:0]           gate_len,
    input  logic [NCH-1:0][W-1:0]  bin_i,
    output logic [NCH-1:0][W-1:0]  result_o,
    output logic                   toggle_o
);
    typedef struct packed {
        logic [W-1:0]          timer;
        logic [NCH-1:0][W-1:0] prev;
        logic [NCH-1:0][W-1:0] res;
        logic                  tog;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (gate_len == '0) begin
            st_d.timer = '0;
            st_d.prev  = bin_i;
        end else if (st_q.timer >= gate_len - 1'b1) begin
            st_d.timer = '0;
            for (int i = 0; i < NCH; i++) begin
                st_d.res[i]  = bin_i[i] - st_q.prev[i];
                st_d.prev[i] = bin_i[i];
            end
            st_d.tog = ~st_q.tog;
        end else begin
            st_d.timer = st_q.timer + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign toggle_o = st_q.tog;
endmodule

// File: rtl/fm_bus_side.sv
module fm_bus_side #(
    parameter int NCH = 3,
    parameter int W   = 32,
    parameter int AW  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  toggle_i,
    input  logic [NCH-1:0][W-1:0] result_i,
    input  logic                  rd_en,
    input  logic [AW-1:0]         rd_addr,
    output logic [W-1:0]          rd_data,
    output logic                  flag_o,
    output logic                  cap_o
);
    typedef struct packed {
        logic                  sync1;
        logic                  sync2;
        logic                  seen;
        logic [NCH-1:0][W-1:0] snap;
        logic                  flag;
        logic [W-1:0]          rdata;
    } st_t;

    st_t  st_d, st_q;
    logic cap;

    assign cap = st_q.sync2 ^ st_q.seen;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = toggle_i;
        st_d.sync2 = st_q.sync1;
        st_d.seen  = st_q.sync2;
        if (cap) st_d.snap = result_i;
        if (rd_en && rd_addr == AW'(NCH)) st_d.flag = 1'b0;
        if (cap) st_d.flag = 1'b1;
        if (rd_en) begin
            st_d.rdata = '0;
            for (int i = 0; i < NCH; i++) begin
                if (rd_addr == AW'(i)) st_d.rdata = st_q.snap[i];
            end
            if (rd_addr == AW'(NCH)) st_d.rdata = {{(W-1){1'b0}}, st_q.flag};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign flag_o  = st_q.flag;
    assign cap_o   = cap;
endmodule

// File: rtl/clkrate_meter.sv
module clkrate_meter
    import clkrate_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int W   = CNT_W,
    localparam int AW = $clog2(NCH + 1) + 1
) (
    input  logic [NCH-1:0] clk_in,
    input  logic           cnt_clk,
    input  logic           bus_clk,
    input  logic           rst_n,
    input  logic [W-1:0]   gate_len,
    input  logic           rd_en,
    input  logic [AW-1:0]  rd_addr,
    output logic [W-1:0]   rd_data
);
    logic [NCH-1:0][W-1:0] src_gray;
    logic [NCH-1:0][W-1:0] sync_gray;
    logic [NCH-1:0][W-1:0] sync_bin;
    logic [NCH-1:0][W-1:0] results;
    logic                  toggle;
    logic                  new_flag;
    logic                  capture;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fm_edge_counter #(.W(W)) u_cnt (
            .clk    (clk_in[c]),
            .rst_n  (rst_n),
            .gray_o (src_gray[c])
        );
        fm_gray_sync #(.W(W)) u_sync (
            .clk    (cnt_clk),
            .rst_n  (rst_n),
            .gray_i (src_gray[c]),
            .gray_o (sync_gray[c]),
            .bin_o  (sync_bin[c])
        );
    end

    fm_gate_core #(.NCH(NCH), .W(W)) u_gate (
        .clk      (cnt_clk),
        .rst_n    (rst_n),
        .gate_len (gate_len),
        .bin_i    (sync_bin),
        .result_o (results),
        .toggle_o (toggle)
    );

    fm_bus_side #(.NCH(NCH), .W(W), .AW(AW)) u_bus (
        .clk      (bus_clk),
        .rst_n    (rst_n),
        .toggle_i (toggle),
        .result_i (results),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .flag_o   (new_flag),
        .cap_o    (capture)
    );
endmodule

// File: rtl/clkrate_meter_chk.sv
module clkrate_meter_chk #(
    parameter int NCH = 3,
    parameter int W   = 32,
    parameter int AW  = 3
) (
    input logic                  cnt_clk,
    input logic                  bus_clk,
    input logic                  rst_n,
    input logic [W-1:0]          gate_len,
    input logic [NCH-1:0][W-1:0] sync_gray,
    input logic [NCH-1:0][W-1:0] results,
    input logic                  toggle,
    input logic                  new_flag,
    input logic                  capture,
    input logic                  rd_en,
    input logic [AW-1:0]         rd_addr
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3: one bit per counting cycle
        a_r3_gray_step: assert property (@(posedge cnt_clk) disable iff (!rst_n)
            $countones(sync_gray[c] ^ $past(sync_gray[c])) <= 1);
    end

    // R4: zero gate leaves the toggle alone
    a_r4_zero_gate_hold: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        (gate_len == '0) |=> $stable(toggle));

    // R7: results move only together with the toggle
    a_r7_results_with_toggle: assert property (@(posedge cnt_clk) disable iff (!rst_n)
        $stable(toggle) |-> $stable(results));

    // R7: flag rises only after a capture
    a_r7_flag_from_capture: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $rose(new_flag) |-> $past(capture));

    // R8: status read clears the flag unless a capture coincides
    a_r8_read_clears: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (rd_en && rd_addr == AW'(NCH) && !capture) |=> !new_flag);

    // R8: a capture always leaves the flag set
    a_r8_capture_wins: assert property (@(posedge bus_clk) disable iff (!rst_n)
        capture |=> new_flag);
endmodule

bind clkrate_meter clkrate_meter_chk #(.NCH(NCH), .W(W), .AW(AW)) u_chk (
    .cnt_clk   (cnt_clk),
    .bus_clk   (bus_clk),
    .rst_n     (rst_n),
    .gate_len  (gate_len),
    .sync_gray (sync_gray),
    .results   (results),
    .toggle    (toggle),
    .new_flag  (new_flag),
    .capture   (capture),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr)
);

// File: tb/clkrate_meter_bench.sv
`timescale 1ns/1ps
module clkrate_meter_bench;
    localparam int NCH = 3;
    localparam int W   = 32;
    localparam int AW  = $clog2(NCH + 1) + 1;
    localparam int STAT = NCH;
    localparam int CNT_PER = 10;

    logic [NCH-1:0] clk_in = '0;
    logic cnt_clk = 1'b0;
    logic bus_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic [W-1:0] gate_len = '0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0] rd_data;
    logic en1 = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    int periods [NCH] = '{20, 30, 50};

    always #5  cnt_clk = ~cnt_clk;
    always #7  bus_clk = ~bus_clk;
    always #10 clk_in[0] = ~clk_in[0];
    always #15 if (en1) clk_in[1] = ~clk_in[1];
    always #25 clk_in[2] = ~clk_in[2];

    clkrate_meter u_clkrate_meter (
        .clk_in   (clk_in),
        .cnt_clk  (cnt_clk),
        .bus_clk  (bus_clk),
        .rst_n    (rst_n),
        .gate_len (gate_len),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    task automatic check_eq(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int ch, input logic [W-1:0] act, input int g);
        longint diff;
        n_tests++;
        diff = longint'(act) * periods[ch] - longint'(g) * CNT_PER;
        if (diff < 0) diff = -diff;
        if (diff > periods[ch]) begin
            n_fail++;
            $display("FAIL %s: ch%0d got %0d expected %0d", req, ch, act, g * CNT_PER / periods[ch]);
        end
    endtask

    task automatic rd(input int a, output logic [W-1:0] v);
        @(negedge bus_clk);
        rd_en   = 1'b1;
        rd_addr = AW'(a);
        @(negedge bus_clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic set_gate(input int g);
        @(negedge cnt_clk);
        gate_len = W'(g);
    endtask

    task automatic wait_new(input string req);
        logic [W-1:0] v;
        for (int k = 0; k < 600; k++) begin
            rd(STAT, v);
            if (v[0]) return;
        end
        n_tests++;
        n_fail++;
        $display("FAIL %s: got 0 expected 1 (no new data)", req);
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        for (int c = 0; c < NCH; c++) begin
            rd(c, v);
            check_eq("R1 result after reset", v, '0);
        end
        rd(STAT, v);
        check_eq("R1 status after reset", v, '0);
    endtask

    task automatic t_disabled;
        logic [W-1:0] v;
        set_gate(0);
        #3000;
        rd(STAT, v);
        check_eq("R4 no update with zero gate", v, '0);
        rd(0, v);
        check_eq("R4 result untouched with zero gate", v, '0);
    endtask

    task automatic t_measure(input int g);
        logic [W-1:0] v;
        set_gate(g);
        wait_new("R7 first publish");
        wait_new("R7 second publish");
        rd(STAT, v);
        check_eq("R8 flag cleared by read", v, '0);
        for (int c = 0; c < NCH; c++) begin
            rd(c, v);
            check_near("R2 edge count", c, v, g);
        end
    endtask

    task automatic t_stopped;
        logic [W-1:0] v;
        en1 = 1'b0;
        set_gate(100);
        wait_new("R5 publish");
        wait_new("R5 publish");
        rd(1, v);
        check_eq("R5 stopped channel reports zero", v, '0);
        rd(0, v);
        check_near("R5 running channel", 0, v, 100);
        en1 = 1'b1;
    endtask

    task automatic t_reenable;
        logic [W-1:0] v;
        set_gate(0);
        #4000;
        rd(STAT, v);
        set_gate(150);
        wait_new("R6 publish");
        for (int c = 0; c < NCH; c++) begin
            rd(c, v);
            check_near("R6 first result covers one interval", c, v, 150);
        end
    endtask

    task automatic t_bad_addr;
        logic [W-1:0] v;
        rd(STAT + 1, v);
        check_eq("R9 address above status", v, '0);
        rd((1 << AW) - 1, v);
        check_eq("R9 top address", v, '0);
    endtask

    initial begin
        #3_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #52;
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_measure(100);
        t_measure(300);
        t_stopped();
        t_measure(100);
        t_reenable();
        t_bad_addr();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule